// File: doc/BRIEF.md
# Source Operand Collector with Constant Substitution

This block sits in front of a computation unit and gathers its source operands for one operation at a time. When an operation is accepted, each source slot either asks the register file for its value or is filled at once with a constant. Two substitutions exist, and each belongs to one slot only. A zero flag forces slot 0 to the value zero. An immediate-valid flag loads slot 1 with the supplied immediate. A slot that is substituted never raises its register read request, so no read-port bandwidth is spent on it.

Slots that are not substituted raise a read request. They capture the register data in the cycle their grant arrives. When every slot holds its value, the block raises an all-ready indication. An issue pulse then empties all slots and returns the collector to idle. The flags and the immediate are captured at operation start. Later changes on those inputs have no effect on the operation in flight.

Top module: `opc_operand_collect`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o, all_ready_o, every rd_req_o bit and every src_o bit are 0.
- R2: start_i high while busy_o is 0 makes busy_o 1 on the next cycle. start_i while busy_o is 1 has no effect on any output.
- R3: If zero_a_i was high at the accepted start, slot 0 (src_o bits [DATA_W-1:0]) reads 0, is ready at once, and rd_req_o[0] stays 0 for the whole operation.
- R4: If imm_ok_i was high at the accepted start, slot 1 (src_o bits [2*DATA_W-1:DATA_W]) holds imm_i as sampled at start, is ready at once, and rd_req_o[1] stays 0 for the whole operation.
- R5: Substitution is tied to fixed slots. zero_a_i never changes slot 1 or any higher slot. imm_ok_i never changes slot 0 or any slot above 1. Those slots still request their reads.
- R6: While busy, rd_req_o[i] is 1 for each slot i that is not yet ready. When rd_gnt_i[i] is high with rd_req_o[i], slot i (src_o bits [i*DATA_W +: DATA_W]) takes rd_data_i bits [i*DATA_W +: DATA_W] on the next cycle, and rd_req_o[i] drops.
- R7: A grant on a slot with no outstanding request is ignored. This covers an idle slot and an already filled slot, and its data is not captured.
- R8: all_ready_o is 1 exactly when busy and every slot is ready. All read requests are then 0.
- R9: issue_i while all_ready_o is 1 makes busy_o, all_ready_o and all src_o bits 0 on the next cycle. issue_i at any other time is ignored.
- R10: Changes on zero_a_i, imm_ok_i or imm_i after the accepted start do not alter the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin collecting operands for a new operation |
| zero_a_i | input | 1 | Force slot 0 to zero and skip its read |
| imm_ok_i | input | 1 | Load slot 1 from imm_i and skip its read |
| imm_i | input | DATA_W | Immediate value for slot 1 |
| issue_i | input | 1 | Hand the collected operands to the unit and clear |
| rd_gnt_i | input | NUM_SRC | Per-slot read grant |
| rd_data_i | input | NUM_SRC*DATA_W | Per-slot read data, slot i at [i*DATA_W +: DATA_W] |
| rd_req_o | output | NUM_SRC | Per-slot read request |
| src_o | output | NUM_SRC*DATA_W | Assembled source operands, slot i at [i*DATA_W +: DATA_W] |
| all_ready_o | output | 1 | Every source slot holds its value |
| busy_o | output | 1 | An operation is being collected |

## Verification
The assertions assume grants are only meaningful together with a request. They also assume issue and start are single pulses the upstream logic times against all_ready_o and busy_o. The checker keeps its own copy of the flags and the immediate, taken at each accepted start, to judge the substituted slots. The stimulus breaks these usage patterns on purpose: it drives grants on idle and already filled slots, start during an operation, issue before all_ready_o, and flags that change mid-operation. Every output is compared on every cycle with a behavioural model that follows the requirements.

// File: rtl/opc_pkg.sv
package opc_pkg;
  typedef enum logic [1:0] {
    SLOT_PLAIN = 2'd0,
    SLOT_ZERO  = 2'd1,
    SLOT_IMM   = 2'd2
  } slot_kind_e;

  // Constant substitution is bound to fixed slot positions.
  function automatic slot_kind_e kind_of(input int idx);
    if (idx == 0) return SLOT_ZERO;
    if (idx == 1) return SLOT_IMM;
    return SLOT_PLAIN;
  endfunction
endpackage

// File: rtl/opc_ctrl.sv
module opc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic issue_i,
  input  logic all_filled_i,
  output logic busy_o,
  output logic load_o,
  output logic clear_o
);
  logic busy_q;

  assign load_o  = start_i & ~busy_q;
  assign clear_o = issue_i & busy_q & all_filled_i;
  assign busy_o  = busy_q;

  always_ff @(posedge clk) begin
    if (rst)          busy_q <= 1'b0;
    else if (clear_o) busy_q <= 1'b0;
    else if (load_o)  busy_q <= 1'b1;
  end
endmodule

// File: rtl/opc_slot.sv
module opc_slot #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic              subst_en_i,
  input  logic [DATA_W-1:0] subst_val_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] val_o
);
  logic              ready_q;
  logic [DATA_W-1:0] val_q;

  assign req_o   = busy_i & ~ready_q;
  assign ready_o = ready_q;
  assign val_o   = val_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      ready_q <= 1'b0;
      val_q   <= '0;
    end else if (load_i) begin
      ready_q <= subst_en_i;
      val_q   <= subst_en_i ? subst_val_i : '0;
    end else if (req_o && gnt_i) begin
      ready_q <= 1'b1;
      val_q   <= data_i;
    end
  end
endmodule

// File: rtl/opc_operand_collect.sv
module opc_operand_collect #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      zero_a_i,
  input  logic                      imm_ok_i,
  input  logic [DATA_W-1:0]         imm_i,
  input  logic                      issue_i,
  input  logic [NUM_SRC-1:0]        rd_gnt_i,
  input  logic [NUM_SRC*DATA_W-1:0] rd_data_i,
  output logic [NUM_SRC-1:0]        rd_req_o,
  output logic [NUM_SRC*DATA_W-1:0] src_o,
  output logic                      all_ready_o,
  output logic                      busy_o
);
  import opc_pkg::*;

  localparam int BUS_W = NUM_SRC * DATA_W;

  logic               busy;
  logic               load;
  logic               clear;
  logic [NUM_SRC-1:0] ready;
  logic [NUM_SRC-1:0] subst_en;
  logic [BUS_W-1:0]   subst_val;

  opc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .issue_i      (issue_i),
    .all_filled_i (&ready),
    .busy_o       (busy),
    .load_o       (load),
    .clear_o      (clear)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    if (kind_of(i) == SLOT_ZERO) begin : g_zero
      assign subst_en[i]                     = zero_a_i;
      assign subst_val[i*DATA_W +: DATA_W]   = '0;
    end else if (kind_of(i) == SLOT_IMM) begin : g_imm
      assign subst_en[i]                     = imm_ok_i;
      assign subst_val[i*DATA_W +: DATA_W]   = imm_i;
    end else begin : g_plain
      assign subst_en[i]                     = 1'b0;
      assign subst_val[i*DATA_W +: DATA_W]   = '0;
    end

    opc_slot #(.DATA_W(DATA_W)) u_slot (
      .clk         (clk),
      .rst         (rst),
      .busy_i      (busy),
      .load_i      (load),
      .clear_i     (clear),
      .subst_en_i  (subst_en[i]),
      .subst_val_i (subst_val[i*DATA_W +: DATA_W]),
      .gnt_i       (rd_gnt_i[i]),
      .data_i      (rd_data_i[i*DATA_W +: DATA_W]),
      .req_o       (rd_req_o[i]),
      .ready_o     (ready[i]),
      .val_o       (src_o[i*DATA_W +: DATA_W])
    );
  end

  assign all_ready_o = busy & (&ready);
  assign busy_o      = busy;
endmodule

// File: rtl/opc_operand_collect_chk.sv
module opc_operand_collect_chk #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start_i,
  input logic                      zero_a_i,
  input logic                      imm_ok_i,
  input logic [DATA_W-1:0]         imm_i,
  input logic                      issue_i,
  input logic [NUM_SRC-1:0]        rd_gnt_i,
  input logic [NUM_SRC-1:0]        rd_req_o,
  input logic [NUM_SRC*DATA_W-1:0] src_o,
  input logic                      all_ready_o,
  input logic                      busy_o
);
  logic              zero_held;
  logic              imm_held;
  logic [DATA_W-1:0] imm_val_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_held    <= 1'b0;
      imm_held     <= 1'b0;
      imm_val_held <= '0;
    end else if (start_i && !busy_o) begin
      zero_held    <= zero_a_i;
      imm_held     <= imm_ok_i;
      imm_val_held <= imm_i;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk)
    !busy_o |-> (rd_req_o == '0) && !all_ready_o && (src_o == '0));

  a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  a_r3_zero_slot: assert property (@(posedge clk) disable iff (rst)
    (busy_o && zero_held) |-> !rd_req_o[0] && (src_o[DATA_W-1:0] == '0));

  a_r4_imm_slot: assert property (@(posedge clk) disable iff (rst)
    (busy_o && imm_held) |-> !rd_req_o[1] && (src_o[2*DATA_W-1:DATA_W] == imm_val_held));

  a_r6_req_drops: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ((rd_req_o & $past(rd_req_o & rd_gnt_i)) == '0));

  a_r8_ready_no_req: assert property (@(posedge clk) disable iff (rst)
    all_ready_o |-> busy_o && (rd_req_o == '0));

  a_r9_issue_clears: assert property (@(posedge clk) disable iff (rst)
    (issue_i && all_ready_o) |=> !busy_o && (src_o == '0));
endmodule

bind opc_operand_collect opc_operand_collect_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .zero_a_i    (zero_a_i),
  .imm_ok_i    (imm_ok_i),
  .imm_i       (imm_i),
  .issue_i     (issue_i),
  .rd_gnt_i    (rd_gnt_i),
  .rd_req_o    (rd_req_o),
  .src_o       (src_o),
  .all_ready_o (all_ready_o),
  .busy_o      (busy_o)
);

// File: tb/opc_operand_collect_tb.sv
module opc_operand_collect_tb;
  localparam int N = 6;
  localparam int W = 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start_i = 1'b0, zero_a_i = 1'b0, imm_ok_i = 1'b0, issue_i = 1'b0;
  logic [W-1:0]   imm_i = '0;
  logic [N-1:0]   rd_gnt_i = '0;
  logic [N*W-1:0] rd_data_i = '0;
  logic [N-1:0]   rd_req_o;
  logic [N*W-1:0] src_o;
  logic           all_ready_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  opc_operand_collect #(.NUM_SRC(N), .DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .zero_a_i(zero_a_i),
    .imm_ok_i(imm_ok_i), .imm_i(imm_i), .issue_i(issue_i),
    .rd_gnt_i(rd_gnt_i), .rd_data_i(rd_data_i), .rd_req_o(rd_req_o),
    .src_o(src_o), .all_ready_o(all_ready_o), .busy_o(busy_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit         m_busy;
  bit         m_rdy [N];
  logic [W-1:0] m_val [N];

  function automatic bit m_all();
    bit a = m_busy;
    for (int i = 0; i < N; i++) a &= m_rdy[i];
    return a;
  endfunction

  initial begin
    m_busy = 0;
    for (int i = 0; i < N; i++) begin m_rdy[i] = 0; m_val[i] = '0; end
  end

  always @(posedge clk) begin
    if (rst || (m_busy && issue_i && m_all())) begin
      m_busy = 0;
      for (int i = 0; i < N; i++) begin m_rdy[i] = 0; m_val[i] = '0; end
    end else if (!m_busy && start_i) begin
      m_busy = 1;
      for (int i = 0; i < N; i++) begin
        m_rdy[i] = (i == 0 && zero_a_i) || (i == 1 && imm_ok_i);
        m_val[i] = (i == 1 && imm_ok_i) ? imm_i : '0;
      end
    end else if (m_busy) begin
      for (int i = 0; i < N; i++)
        if (!m_rdy[i] && rd_gnt_i[i]) begin m_rdy[i] = 1; m_val[i] = rd_data_i[i*W +: W]; end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R2 busy", W'(busy_o), W'(m_busy));
      check("R8 all_ready", W'(all_ready_o), W'(m_all()));
      for (int i = 0; i < N; i++) begin
        string t;
        t = (i == 0) ? "R3" : (i == 1) ? "R4" : "R6";
        check({t, " req"}, W'(rd_req_o[i]), W'(m_busy && !m_rdy[i]));
        check({t, " src"}, src_o[i*W +: W], m_val[i]);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic randomize_data();
    for (int i = 0; i < N; i++) rd_data_i[i*W +: W] = {$urandom, $urandom};
  endtask

  task automatic run_op(input bit z, input bit im, input logic [W-1:0] iv);
    logic [W-1:0] d2;
    @(negedge clk); #1;
    start_i = 1; zero_a_i = z; imm_ok_i = im; imm_i = iv; issue_i = 1;
    @(negedge clk); #1;
    start_i = 0; issue_i = 1;           // R9: issue before all ready
    check("R3 req0", W'(rd_req_o[0]), W'(!z));
    check("R4 req1", W'(rd_req_o[1]), W'(!im));
    check("R5 req2", W'(rd_req_o[2]), W'(1));
    if (z)  check("R5 slot1 unaffected by zero", W'(rd_req_o[1]), W'(!im));
    if (im) check("R5 slot0 unaffected by imm", W'(rd_req_o[0]), W'(!z));
    // flip flags mid-operation (R10), restart attempt (R2), grant slot 2
    zero_a_i = !z; imm_ok_i = !im; imm_i = ~iv; start_i = 1;
    randomize_data(); rd_gnt_i = 6'b000100;
    d2 = rd_data_i[2*W +: W];
    @(negedge clk); #1;
    check("R9 early issue ignored", W'(busy_o), W'(1));
    issue_i = 0;
    randomize_data(); rd_gnt_i = 6'b000100;
    @(negedge clk); #1;
    check("R7 refilled slot kept", src_o[2*W +: W], d2);
    start_i = 0; rd_gnt_i = '0;
    for (int k = 0; k < 200 && !all_ready_o; k++) begin
      randomize_data(); rd_gnt_i = N'($urandom);
      zero_a_i = $urandom; imm_ok_i = $urandom; imm_i = {$urandom, $urandom};
      @(negedge clk); #1;
    end
    rd_gnt_i = '0;
    check("R8 reached", W'(all_ready_o), W'(1));
    if (z)  check("R10 slot0 zero", src_o[W-1:0], '0);
    if (im) check("R10 slot1 imm", src_o[2*W-1:W], iv);
    issue_i = 1;
    @(negedge clk); #1;
    issue_i = 0;
    check("R9 busy cleared", W'(busy_o), W'(0));
    check("R9 src cleared", W'(src_o == '0), W'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy", W'(busy_o), W'(0));
    check("R1 req", W'(rd_req_o), W'(0));
    check("R1 src", W'(src_o == '0), W'(1));
    rd_gnt_i = '1; randomize_data();
    rst = 0;
    @(negedge clk); #1;
    check("R1 first cycle", W'(busy_o), W'(0));
    check("R7 idle grant ignored", W'(src_o == '0), W'(1));
    rd_gnt_i = '0;
    run_op(0, 0, '0);
    run_op(1, 0, '0);
    run_op(0, 1, 64'hDEAD_BEEF_0123_4567);
    run_op(1, 1, 64'h8000_0000_0000_0001);
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); #1;
      start_i = ($urandom % 4) == 0;
      zero_a_i = $urandom; imm_ok_i = $urandom; imm_i = {$urandom, $urandom};
      issue_i = ($urandom % 3) == 0;
      rd_gnt_i = N'($urandom);
      randomize_data();
    end
    @(negedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule